// File: doc/BRIEF.md
# Slave-FIFO Stream Writer with Short-Packet Commit

This block sits on the FPGA side of a synchronous slave-FIFO link to a USB bridge. A producer pushes words into a local upstream buffer with no backpressure. The writer moves those words onto the bridge's data bus whenever the bridge reports that its endpoint has room. It drives an active-low write strobe and an active-low packet-end line.

A packet can be closed early as a short packet in two ways: software sends a request pulse, or an optional periodic timer fires. The close is marked by asserting packet-end together with the strobe of the next word that goes out. If no word is waiting, the close is held back until a word arrives. When zero-length commits are enabled, it is instead sent at once as a packet-end pulse with no strobe. After every commit the writer stays quiet for a fixed number of cycles. This covers the bridge's ready flag, which only drops some cycles after the commit.

When the upstream buffer is full, any further incoming word is lost. Each such loss is recorded in a sticky flag and a saturating counter. A wrapping counter records how many packets have been committed.

Top module: `sfw_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_wr_n` and `bus_pktend_n` are 1, and `overflow`, `drop_count` and `commit_count` are 0.
- R2: Words leave in arrival order. `bus_wr_n` is 0 in exactly those cycles in which `bridge_rdy` is 1, the buffer is not empty and no hold-off is running. In such a cycle `bus_data` carries the oldest stored word.
- R3: In a cycle where `bridge_rdy` is 0, both `bus_wr_n` and `bus_pktend_n` are 1.
- R4: A 1 on `commit_req` at a clock edge makes a commit pending from the next cycle on. The next word written after that carries `bus_pktend_n` = 0 in the same cycle as its `bus_wr_n` = 0.
- R5: While `zlp_en` is 0 and the buffer is empty, a pending commit produces no packet-end and stays pending until a word is written.
- R6: While `zlp_en` is 1, a pending commit with the buffer empty, `bridge_rdy` at 1 and no hold-off gives one cycle with `bus_pktend_n` = 0 and `bus_wr_n` = 1.
- R7: After any cycle with `bus_pktend_n` = 0, the next `READY_LAT` cycles have `bus_wr_n` and `bus_pktend_n` both at 1, whatever the value of `bridge_rdy`.
- R8: While `timer_en` is 1, the timer raises a commit request once every `TIMER_PERIOD` cycles. The first request comes `TIMER_PERIOD` cycles after `timer_en` rises. While `timer_en` is 0, the timer is held at zero.
- R9: Any number of requests, from either source, that arrive while a commit is already pending produce a single commit.
- R10: A 1 on `in_valid` while the buffer holds `FIFO_DEPTH` words drops that word. It sets `overflow`, which stays 1 until reset, and it adds 1 to `drop_count`, which saturates at its maximum value.
- R11: `commit_count` adds 1 for every commit, whether carried by a word or zero-length. It wraps to 0 after its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer word strobe |
| in_data | input | DATA_W | Producer word |
| bridge_rdy | input | 1 | Bridge endpoint can accept data (1 = ready) |
| commit_req | input | 1 | Software request to close the current packet |
| timer_en | input | 1 | Enables the periodic commit timer |
| zlp_en | input | 1 | Allows zero-length commits when no word is waiting |
| bus_data | output | DATA_W | Data bus to the bridge |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_pktend_n | output | 1 | Packet end, active low |
| overflow | output | 1 | Sticky flag for a lost word |
| drop_count | output | DROP_W | Saturating count of lost words |
| commit_count | output | CNT_W | Wrapping count of committed packets |

## Verification
A software request and a timer tick can land while a commit is already pending. Both sources feed the same pending flag, so the right outcome is still exactly one packet-end. The bench provokes this with an empty buffer and zero-length commits disabled. It raises a software request, then lets the timer tick twice while that request waits, then pushes a single word. It passes only if `commit_count` grows by one and the following word goes out without packet-end.

// File: rtl/sfw_pkg.sv
// Package: shared types for the slave-FIFO stream writer.
// Assumes: nothing beyond IEEE 1800-2017.
package sfw_pkg;

    // Kind of commit performed in a cycle.
    typedef enum logic [1:0] {
        CMT_NONE  = 2'd0,
        CMT_DATA  = 2'd1,
        CMT_EMPTY = 2'd2
    } commit_kind_e;

endpackage

// File: rtl/sfw_fifo.sv
// Module: upstream word buffer with loss detection.
// Stores producer words in order. A word offered while the buffer is full is
// dropped and recorded in a sticky flag and a saturating counter.
// Assumes: pop is only raised while the buffer is not empty.
module sfw_fifo #(
    parameter int W      = 32,
    parameter int DEPTH  = 16,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [W-1:0]      push_data,
    input  logic              pop,
    output logic [W-1:0]      head,
    output logic              empty,
    output logic              overflow,
    output logic [DROP_W-1:0] drop_count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] fill;
    logic          full, accept, drop;

    assign full   = (fill == FULL_CNT);
    assign empty  = (fill == '0);
    assign accept = push_valid && !full;
    assign drop   = push_valid && full;
    assign head   = mem[rd_ptr];

    // Store accepted words at the write pointer.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop)    rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({accept, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Record lost words: sticky flag plus saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow   <= 1'b0;
            drop_count <= '0;
        end else if (drop) begin
            overflow <= 1'b1;
            if (drop_count != '1) drop_count <= drop_count + 1'b1;
        end
    end

    assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_drop_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> overflow);
    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: rtl/sfw_commit_sched.sv
// Module: commit request scheduler.
// Merges software request pulses and periodic timer ticks into one pending
// flag, which the transmit engine clears when it performs a commit.
// Assumes: TIMER_PERIOD >= 2.
module sfw_commit_sched #(
    parameter int TIMER_PERIOD = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req,
    input  logic tmr_en,
    input  logic consume,
    output logic pending
);
    localparam int TW = $clog2(TIMER_PERIOD);
    localparam logic [TW-1:0] TMR_LAST = TW'(TIMER_PERIOD - 1);

    logic [TW-1:0] tmr;
    logic          tick;

    assign tick = tmr_en && (tmr == TMR_LAST);

    // Periodic timer: runs while enabled, held at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !tmr_en) tmr <= '0;
        else if (tick)         tmr <= '0;
        else                   tmr <= tmr + 1'b1;
    end

    // Pending flag: any new request sets it, a commit clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending && !consume) || sw_req || tick;
    end

    assert_req_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> pending);
    assert_pend_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !consume) |=> pending);

endmodule

// File: rtl/sfw_tx_engine.sv
// Module: bus transmit engine.
// Decides each cycle whether to write a word, attach packet end to it, or
// issue a zero-length commit. It enforces the post-commit hold-off and
// counts commits.
// Assumes: HOLD >= 1; bridge_rdy is synchronous to clk.
module sfw_tx_engine
    import sfw_pkg::*;
#(
    parameter int HOLD  = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bridge_rdy,
    input  logic             fifo_empty,
    input  logic             pending,
    input  logic             zlp_en,
    output logic             pop,
    output logic             consume,
    output logic             wr_n,
    output logic             pktend_n,
    output logic [CNT_W-1:0] commit_count
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD);

    logic [HW-1:0] hold;
    logic          slot_ok;
    commit_kind_e  kind;

    assign slot_ok = bridge_rdy && (hold == '0);
    assign pop     = slot_ok && !fifo_empty;

    // Choose the commit kind for this cycle.
    always_comb begin
        kind = CMT_NONE;
        if (pending) begin
            if (pop)                            kind = CMT_DATA;
            else if (zlp_en && slot_ok && fifo_empty) kind = CMT_EMPTY;
        end
    end

    assign consume  = (kind != CMT_NONE);
    assign wr_n     = !pop;
    assign pktend_n = !consume;

    // Hold-off counter loaded on each commit, counted down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           hold <= '0;
        else if (consume)     hold <= HOLD_LOAD;
        else if (hold != '0)  hold <= hold - 1'b1;
    end

    // Wrapping commit counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       commit_count <= '0;
        else if (consume) commit_count <= commit_count + 1'b1;
    end

    assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pktend_n |=> (wr_n && pktend_n));
    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (commit_count == $past(commit_count) + 1'b1));

endmodule

// File: rtl/sfw_writer.sv
// Module: slave-FIFO stream writer, top level.
// Buffers producer words, forwards them to the bridge while it is ready,
// and closes short packets on request or on a timer.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module sfw_writer #(
    parameter int DATA_W       = 32,
    parameter int FIFO_DEPTH   = 16,
    parameter int READY_LAT    = 3,
    parameter int TIMER_PERIOD = 50_000_000,
    parameter int CNT_W        = 16,
    parameter int DROP_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              bridge_rdy,
    input  logic              commit_req,
    input  logic              timer_en,
    input  logic              zlp_en,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_wr_n,
    output logic              bus_pktend_n,
    output logic              overflow,
    output logic [DROP_W-1:0] drop_count,
    output logic [CNT_W-1:0]  commit_count
);
    logic fifo_empty, pop, consume, pending;

    sfw_fifo #(
        .W      (DATA_W),
        .DEPTH  (FIFO_DEPTH),
        .DROP_W (DROP_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (in_valid),
        .push_data  (in_data),
        .pop        (pop),
        .head       (bus_data),
        .empty      (fifo_empty),
        .overflow   (overflow),
        .drop_count (drop_count)
    );

    sfw_commit_sched #(
        .TIMER_PERIOD (TIMER_PERIOD)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_req  (commit_req),
        .tmr_en  (timer_en),
        .consume (consume),
        .pending (pending)
    );

    sfw_tx_engine #(
        .HOLD  (READY_LAT),
        .CNT_W (CNT_W)
    ) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bridge_rdy   (bridge_rdy),
        .fifo_empty   (fifo_empty),
        .pending      (pending),
        .zlp_en       (zlp_en),
        .pop          (pop),
        .consume      (consume),
        .wr_n         (bus_wr_n),
        .pktend_n     (bus_pktend_n),
        .commit_count (commit_count)
    );

    assert_idle_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_rdy |-> (bus_wr_n && bus_pktend_n));
    assert_data_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_pktend_n && !fifo_empty) |-> !bus_wr_n);

endmodule

// File: tb/sfw_writer_tb.sv
`timescale 1ns/1ps
module sfw_writer_tb;
    localparam int W = 8;
    localparam int DEPTH = 4;
    localparam int LAT = 2;
    localparam int TP = 20;
    localparam int CW = 3;
    localparam int DW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, bridge_rdy = 1'b0, commit_req = 1'b0;
    logic timer_en = 1'b0, zlp_en = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] bus_data;
    logic bus_wr_n, bus_pktend_n, overflow;
    logic [DW-1:0] drop_count;
    logic [CW-1:0] commit_count;

    int n_chk = 0, n_bad = 0, busy_viol = 0, exp_cc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sfw_writer #(.DATA_W(W), .FIFO_DEPTH(DEPTH), .READY_LAT(LAT),
                 .TIMER_PERIOD(TP), .CNT_W(CW), .DROP_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .bridge_rdy(bridge_rdy), .commit_req(commit_req), .timer_en(timer_en),
        .zlp_en(zlp_en), .bus_data(bus_data), .bus_wr_n(bus_wr_n),
        .bus_pktend_n(bus_pktend_n), .overflow(overflow),
        .drop_count(drop_count), .commit_count(commit_count));

    // Vector fields: iv, data, rdy, req, exp_wr_n, exp_pktend_n, exp_data
    localparam int NV = 9;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 8'h11, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
        {1'b1, 8'h22, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h22},
        {1'b1, 8'h33, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h33},
        {1'b1, 8'h44, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h44}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to the next cycle's drive point (negedge).
    task automatic next_cycle();
        @(negedge clk);
    endtask

    task automatic sample();
        #1;
    endtask

    // R3 monitor: no strobe or packet end while the bridge is busy.
    always @(negedge clk) begin
        #1;
        if (rst_n && !bridge_rdy && (!bus_wr_n || !bus_pktend_n)) busy_viol++;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) next_cycle();
        sample();
        check("R1 wr_n", bus_wr_n, 1);
        check("R1 pktend_n", bus_pktend_n, 1);
        next_cycle();
        rst_n = 1'b1;
        sample();
        check("R1 overflow", overflow, 0);
        check("R1 drop_count", drop_count, 0);
        check("R1 commit_count", commit_count, 0);

        // Vector table: R2 ordering, R3 busy, R4 commit, R5 hold, R7 hold-off
        for (int i = 0; i < NV; i++) begin
            next_cycle();
            in_valid   = VEC[i][20];
            in_data    = VEC[i][19:12];
            bridge_rdy = VEC[i][11];
            commit_req = VEC[i][10];
            sample();
            check($sformatf("R2/R4/R7 v%0d wr_n", i), bus_wr_n, VEC[i][9]);
            check($sformatf("R4/R5 v%0d pktend_n", i), bus_pktend_n, VEC[i][8]);
            if (!VEC[i][9]) check($sformatf("R2 v%0d data", i), bus_data, VEC[i][7:0]);
        end
        next_cycle();
        in_valid = 0; commit_req = 0;
        exp_cc = 1;
        sample();
        check("R11 count after table", commit_count, exp_cc);

        // R6: zero-length commit
        zlp_en = 1;
        commit_req = 1;
        next_cycle();
        commit_req = 0;
        sample();
        check("R6 zlp pktend_n", bus_pktend_n, 0);
        check("R6 zlp wr_n", bus_wr_n, 1);
        next_cycle();
        sample();
        exp_cc = (exp_cc + 1) % 8;
        check("R11 count after zlp", commit_count, exp_cc);
        zlp_en = 0;
        repeat (3) next_cycle();

        // R10: overflow with bridge busy
        bridge_rdy = 0;
        for (int k = 0; k < 7; k++) begin
            in_valid = 1; in_data = 8'hA0 + 8'(k);
            next_cycle();
        end
        in_valid = 0;
        sample();
        check("R10 overflow", overflow, 1);
        check("R10 drop_count", drop_count, 3);
        for (int k = 0; k < 5; k++) begin
            in_valid = 1; in_data = 8'hF0;
            next_cycle();
        end
        in_valid = 0;
        sample();
        check("R10 drop_count saturates", drop_count, 7);
        // R2: drain preserves order of stored words
        bridge_rdy = 1;
        for (int k = 0; k < 4; k++) begin
            sample();
            check($sformatf("R2 drain %0d wr_n", k), bus_wr_n, 0);
            check($sformatf("R2 drain %0d data", k), bus_data, 8'hA0 + k);
            next_cycle();
        end
        sample();
        check("R2 empty idle", bus_wr_n, 1);
        check("R10 overflow sticky", overflow, 1);

        // R9/R8: request held while timer ticks twice, one commit
        commit_req = 1;
        next_cycle();
        commit_req = 0;
        timer_en = 1;
        repeat (2 * TP + 2) next_cycle();
        timer_en = 0;
        sample();
        check("R5 no commit while empty", commit_count, exp_cc);
        in_valid = 1; in_data = 8'h5A;
        next_cycle();
        in_valid = 0;
        sample();
        check("R9 merged commit wr_n", bus_wr_n, 0);
        check("R9 merged commit pktend_n", bus_pktend_n, 0);
        exp_cc = (exp_cc + 1) % 8;
        repeat (LAT + 1) next_cycle();
        in_valid = 1; in_data = 8'h5B;
        next_cycle();
        in_valid = 0;
        sample();
        check("R9 follow word wr_n", bus_wr_n, 0);
        check("R9 follow word pktend_n", bus_pktend_n, 1);
        check("R9 single commit", commit_count, exp_cc);

        // R8: periodic timer with zero-length commits
        next_cycle();
        zlp_en = 1; timer_en = 1;
        repeat (3 * TP + 4) next_cycle();
        timer_en = 0;
        exp_cc = (exp_cc + 3) % 8;
        sample();
        check("R8 three ticks", commit_count, exp_cc);

        // R11: wrap of the commit counter
        for (int k = 0; k < 8; k++) begin
            commit_req = 1;
            next_cycle();
            commit_req = 0;
            repeat (4) next_cycle();
            exp_cc = (exp_cc + 1) % 8;
            if (k == 1) begin
                sample();
                check("R11 wraps to zero", commit_count, exp_cc);
            end
        end
        sample();
        check("R11 after full wrap", commit_count, exp_cc);

        check("R3 no strobe while busy", busy_viol, 0);
        finish_run();
    end
endmodule